// File: doc/BRIEF.md
# Parallel Display Bus Strobe Timer

This block runs single accesses on an 8080-style parallel display bus. A serializer or host hands it one request at a time: a write of a command or data word, or a read. The block then plays out one access cycle. Chip select, write enable and read enable each switch on and off at their own programmed tick within that cycle. For a read, the bus data is sampled at a programmed tick and returned with a one-clock valid pulse.

A tick is either one interface clock or two, chosen by a coarse-tick input. The edge positions, the two cycle lengths and the read sample time arrive as two packed 32-bit timing words. The block checks these words against a set of ordering rules and refuses to run while they are broken. Each bus pin has its own polarity bit, so panels with active-low or active-high strobes need no outside logic.

Top module: `pbus_strobe_timer`

## Requirements
- R1: While reset is asserted and afterwards until the first request, CS, WE and RE sit at their inactive levels, req_ready_o is high for a valid configuration, rd_valid_o is low and rd_data_o is zero.
- R2: With coarse_tick_i low each tick lasts one clock. With coarse_tick_i high each tick lasts two clocks.
- R3: Ticks in a cycle are numbered from 0. CS is active on every tick t with cs_on <= t < cs_off. cs_on is onoff_cfg_i[3:0] and cs_off is onoff_cfg_i[9:4].
- R4: On write cycles only, WE is active on ticks we_on <= t < we_off. we_on is onoff_cfg_i[13:10] and we_off is onoff_cfg_i[19:14]. bus_d_oe_o is high and bus_d_o carries the request word for the whole write cycle.
- R5: On read cycles only, RE is active on ticks re_on <= t < re_off. re_on is onoff_cfg_i[23:20] and re_off is onoff_cfg_i[29:24]. bus_d_oe_o stays low during a read.
- R6: A read captures bus_d_i on the clock edge that closes tick acc-1, or on the cycle's last edge if acc is past the cycle end. acc is cycle_cfg_i[27:22]. rd_valid_o pulses for one clock right after the cycle ends, and rd_data_o holds the capture until the next one.
- R7: A write cycle lasts max(we_cyc, cs_off) ticks and a read cycle max(re_cyc, cs_off) ticks. we_cyc is cycle_cfg_i[5:0] and re_cyc is cycle_cfg_i[11:6]. A request is taken on an edge where req_valid_i and req_ready_o are both high. req_ready_o is low during the cycle and high again on the clock after its final tick.
- R8: cfg_err_o is high whenever one of these rules fails: we_off > we_on, re_off > re_on, cs_off > cs_on, cs_off >= we_off, cs_off >= re_off, we_cyc >= we_off, re_cyc >= re_off, acc > re_on. While it is high, req_ready_o is low and CS, WE and RE are held inactive.
- R9: The register-select line is latched when a request is taken and holds through the cycle and beyond it. Before polarity it is 0 for a command word (req_data_i low) and 1 for a data word.
- R10: Each pin equals its internal active-high value XOR its pol_i bit. Bit 0 is register select, bit 1 is RE, bit 2 is WE and bit 3 is CS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| onoff_cfg_i | input | 32 | Strobe edge word: CS, WE and RE on/off ticks |
| cycle_cfg_i | input | 32 | Cycle word: write length, read length, read sample tick |
| coarse_tick_i | input | 1 | 1: tick is two clocks; 0: tick is one clock |
| pol_i | input | 4 | Per-pin polarity: [0] select, [1] RE, [2] WE, [3] CS |
| req_valid_i | input | 1 | Access request present |
| req_ready_o | output | 1 | Block can take a request on this edge |
| req_read_i | input | 1 | 1: read access; 0: write access |
| req_data_i | input | 1 | 1: data word; 0: command word |
| req_wdata_i | input | DATA_W | Word to drive on a write |
| rd_valid_o | output | 1 | One-clock pulse when read data is ready |
| rd_data_o | output | DATA_W | Last sampled read word |
| bus_cs_o | output | 1 | Chip select pin |
| bus_we_o | output | 1 | Write enable pin |
| bus_re_o | output | 1 | Read enable pin |
| bus_rs_o | output | 1 | Register-select (command/data) pin |
| bus_d_o | output | DATA_W | Bus data out |
| bus_d_oe_o | output | 1 | Bus data output enable |
| bus_d_i | input | DATA_W | Bus data in |
| cfg_err_o | output | 1 | Timing words break an ordering rule |

## Verification
The bound checker checks several rules on every clock. Strobes stay quiet while the configuration is in error. WE and RE are never active together. The data driver is off whenever RE is active. CS is never active while a new request could be taken. The select line does not move inside a cycle, and the read-valid pulse never lasts more than one clock. What only the bench's scenarios can show is the exact tick on which each edge falls, the stretching of ticks in coarse mode, the cycle length when cs_off passes the cycle count, and which bus word a read captures. For these it compares every pin each clock against a behavioural model, across normal, inverted, single-tick, late-sample, back-to-back and error configurations.

// File: rtl/pbst_pkg.sv
package pbst_pkg;
  localparam int CFG_W = 32;
  localparam int ON_W  = 4;
  localparam int OFF_W = 6;
  localparam int N_STB = 3;
  localparam int STB_CS = 0;
  localparam int STB_WE = 1;
  localparam int STB_RE = 2;
  localparam int POL_RS = 0;
  localparam int POL_RE = 1;
  localparam int POL_WE = 2;
  localparam int POL_CS = 3;

  typedef struct packed {
    logic [ON_W-1:0]  cs_on;
    logic [OFF_W-1:0] cs_off;
    logic [ON_W-1:0]  we_on;
    logic [OFF_W-1:0] we_off;
    logic [ON_W-1:0]  re_on;
    logic [OFF_W-1:0] re_off;
    logic [OFF_W-1:0] we_cyc;
    logic [OFF_W-1:0] re_cyc;
    logic [OFF_W-1:0] acc;
  } tim_t;

  function automatic tim_t unpack_tim(input logic [CFG_W-1:0] onoff,
                                      input logic [CFG_W-1:0] cyc);
    tim_t t;
    t.cs_on  = onoff[3:0];
    t.cs_off = onoff[9:4];
    t.we_on  = onoff[13:10];
    t.we_off = onoff[19:14];
    t.re_on  = onoff[23:20];
    t.re_off = onoff[29:24];
    t.we_cyc = cyc[5:0];
    t.re_cyc = cyc[11:6];
    t.acc    = cyc[27:22];
    return t;
  endfunction

  function automatic logic [OFF_W-1:0] ext_on(input logic [ON_W-1:0] v);
    return OFF_W'(v);
  endfunction
endpackage

// File: rtl/pbst_cfg_check.sv
module pbst_cfg_check
  import pbst_pkg::*;
(
  input  tim_t tim_i,
  output logic err_o
);
  always_comb begin
    err_o = 1'b0;
    if (tim_i.we_off <= ext_on(tim_i.we_on)) err_o = 1'b1;
    if (tim_i.re_off <= ext_on(tim_i.re_on)) err_o = 1'b1;
    if (tim_i.cs_off <= ext_on(tim_i.cs_on)) err_o = 1'b1;
    if (tim_i.cs_off < tim_i.we_off)         err_o = 1'b1;
    if (tim_i.cs_off < tim_i.re_off)         err_o = 1'b1;
    if (tim_i.we_cyc < tim_i.we_off)         err_o = 1'b1;
    if (tim_i.re_cyc < tim_i.re_off)         err_o = 1'b1;
    if (tim_i.acc <= ext_on(tim_i.re_on))    err_o = 1'b1;
  end
endmodule

// File: rtl/pbst_sequencer.sv
module pbst_sequencer
  import pbst_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tim_t              tim_i,
  input  logic              coarse_i,
  input  logic              err_i,
  input  logic              req_valid_i,
  input  logic              req_read_i,
  input  logic              req_data_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] bus_d_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic              is_read_o,
  output logic              rs_o,
  output logic [OFF_W-1:0]  tick_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              busy_q, phase_q, read_q, rs_q, rd_valid_q;
  logic [OFF_W-1:0]  tick_q, cyc_len, last_tick;
  logic [DATA_W-1:0] wdata_q, rd_data_q;
  logic              tick_en, at_end, sample_now;

  always_comb begin
    cyc_len = read_q ? tim_i.re_cyc : tim_i.we_cyc;
    if (tim_i.cs_off > cyc_len) cyc_len = tim_i.cs_off;
    last_tick  = cyc_len - OFF_W'(1);
    tick_en    = busy_q && (!coarse_i || phase_q);
    at_end     = tick_en && (tick_q == last_tick);
    // sample closes tick acc-1; a late acc falls back to the last edge
    sample_now = tick_en && read_q &&
                 ((tick_q + OFF_W'(1) == tim_i.acc) || (at_end && (tim_i.acc > cyc_len)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      phase_q    <= 1'b0;
      read_q     <= 1'b0;
      rs_q       <= 1'b0;
      rd_valid_q <= 1'b0;
      tick_q     <= '0;
      wdata_q    <= '0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= 1'b0;
      if (!busy_q) begin
        if (req_valid_i && ready_o) begin
          busy_q  <= 1'b1;
          phase_q <= 1'b0;
          tick_q  <= '0;
          read_q  <= req_read_i;
          rs_q    <= req_data_i;
          wdata_q <= req_wdata_i;
        end
      end else begin
        if (coarse_i) phase_q <= ~phase_q;
        if (sample_now) rd_data_q <= bus_d_i;
        if (at_end) begin
          busy_q     <= 1'b0;
          rd_valid_q <= read_q;
        end else if (tick_en) begin
          tick_q <= tick_q + OFF_W'(1);
        end
      end
    end
  end

  logic unused_tim;
  assign unused_tim = ^tim_i;

  assign ready_o    = !busy_q && !err_i;
  assign busy_o     = busy_q;
  assign is_read_o  = read_q;
  assign rs_o       = rs_q;
  assign tick_o     = tick_q;
  assign wdata_o    = wdata_q;
  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;
endmodule

// File: rtl/pbst_pins.sv
module pbst_pins
  import pbst_pkg::*;
(
  input  tim_t             tim_i,
  input  logic             busy_i,
  input  logic             is_read_i,
  input  logic             rs_i,
  input  logic             err_i,
  input  logic [OFF_W-1:0] tick_i,
  input  logic [3:0]       pol_i,
  output logic             cs_o,
  output logic             we_o,
  output logic             re_o,
  output logic             rs_o
);
  logic [ON_W-1:0]  on_t  [N_STB];
  logic [OFF_W-1:0] off_t [N_STB];
  logic [N_STB-1:0] sel, act;

  assign on_t[STB_CS]  = tim_i.cs_on;
  assign off_t[STB_CS] = tim_i.cs_off;
  assign sel[STB_CS]   = 1'b1;
  assign on_t[STB_WE]  = tim_i.we_on;
  assign off_t[STB_WE] = tim_i.we_off;
  assign sel[STB_WE]   = !is_read_i;
  assign on_t[STB_RE]  = tim_i.re_on;
  assign off_t[STB_RE] = tim_i.re_off;
  assign sel[STB_RE]   = is_read_i;

  for (genvar g = 0; g < N_STB; g++) begin : g_win
    assign act[g] = busy_i && !err_i && sel[g] &&
                    (tick_i >= ext_on(on_t[g])) && (tick_i < off_t[g]);
  end

  logic unused_tim;
  assign unused_tim = ^tim_i;

  assign cs_o = act[STB_CS] ^ pol_i[POL_CS];
  assign we_o = act[STB_WE] ^ pol_i[POL_WE];
  assign re_o = act[STB_RE] ^ pol_i[POL_RE];
  assign rs_o = rs_i ^ pol_i[POL_RS];
endmodule

// File: rtl/pbus_strobe_timer.sv
module pbus_strobe_timer
  import pbst_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CFG_W-1:0]  onoff_cfg_i,
  input  logic [CFG_W-1:0]  cycle_cfg_i,
  input  logic              coarse_tick_i,
  input  logic [3:0]        pol_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_read_i,
  input  logic              req_data_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              bus_cs_o,
  output logic              bus_we_o,
  output logic              bus_re_o,
  output logic              bus_rs_o,
  output logic [DATA_W-1:0] bus_d_o,
  output logic              bus_d_oe_o,
  input  logic [DATA_W-1:0] bus_d_i,
  output logic              cfg_err_o
);
  tim_t             tim;
  logic             busy, is_read, rs_int;
  logic [OFF_W-1:0] tick;
  logic [DATA_W-1:0] wdata;

  assign tim = unpack_tim(onoff_cfg_i, cycle_cfg_i);

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{onoff_cfg_i[31:30], cycle_cfg_i[31:28], cycle_cfg_i[21:12]};

  pbst_cfg_check u_check (
    .tim_i (tim),
    .err_o (cfg_err_o)
  );

  pbst_sequencer #(.DATA_W(DATA_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tim_i       (tim),
    .coarse_i    (coarse_tick_i),
    .err_i       (cfg_err_o),
    .req_valid_i (req_valid_i),
    .req_read_i  (req_read_i),
    .req_data_i  (req_data_i),
    .req_wdata_i (req_wdata_i),
    .bus_d_i     (bus_d_i),
    .ready_o     (req_ready_o),
    .busy_o      (busy),
    .is_read_o   (is_read),
    .rs_o        (rs_int),
    .tick_o      (tick),
    .wdata_o     (wdata),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o)
  );

  pbst_pins u_pins (
    .tim_i     (tim),
    .busy_i    (busy),
    .is_read_i (is_read),
    .rs_i      (rs_int),
    .err_i     (cfg_err_o),
    .tick_i    (tick),
    .pol_i     (pol_i),
    .cs_o      (bus_cs_o),
    .we_o      (bus_we_o),
    .re_o      (bus_re_o),
    .rs_o      (bus_rs_o)
  );

  assign bus_d_o    = wdata;
  assign bus_d_oe_o = busy && !is_read;
endmodule

// File: rtl/pbst_chk.sv
module pbst_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_err_o,
  input logic [3:0] pol_i,
  input logic       bus_cs_o,
  input logic       bus_we_o,
  input logic       bus_re_o,
  input logic       bus_rs_o,
  input logic       bus_d_oe_o,
  input logic       req_ready_o,
  input logic       rd_valid_o,
  input logic       busy
);
  // R8
  no_strobe_on_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (bus_cs_o == pol_i[3] && bus_we_o == pol_i[2] && bus_re_o == pol_i[1]));

  // R4 R5
  we_re_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((bus_we_o ^ pol_i[2]) && (bus_re_o ^ pol_i[1])));

  // R5
  no_drive_in_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_re_o ^ pol_i[1]) |-> !bus_d_oe_o);

  // R7
  no_accept_in_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cs_o ^ pol_i[3]) |-> !req_ready_o);

  // R9
  rs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy) && $stable(pol_i)) |-> $stable(bus_rs_o));

  // R6
  rd_valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);
endmodule

bind pbus_strobe_timer pbst_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_err_o   (cfg_err_o),
  .pol_i       (pol_i),
  .bus_cs_o    (bus_cs_o),
  .bus_we_o    (bus_we_o),
  .bus_re_o    (bus_re_o),
  .bus_rs_o    (bus_rs_o),
  .bus_d_oe_o  (bus_d_oe_o),
  .req_ready_o (req_ready_o),
  .rd_valid_o  (rd_valid_o),
  .busy        (busy)
);

// File: tb/tb_pbus_strobe_timer.sv
module tb_pbus_strobe_timer;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [31:0]   onoff = '0, cyc = '0;
  logic          coarse = 1'b0;
  logic [3:0]    pol = '0;
  logic          req_valid = 1'b0, req_read = 1'b0, req_data = 1'b0;
  logic [DW-1:0] req_wdata = '0, bus_d_in = '0;
  logic          req_ready, rd_valid, bus_cs, bus_we, bus_re, bus_rs, bus_d_oe, cfg_err;
  logic [DW-1:0] rd_data, bus_d_out;

  pbus_strobe_timer #(.DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .onoff_cfg_i(onoff), .cycle_cfg_i(cyc),
    .coarse_tick_i(coarse), .pol_i(pol), .req_valid_i(req_valid),
    .req_ready_o(req_ready), .req_read_i(req_read), .req_data_i(req_data),
    .req_wdata_i(req_wdata), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .bus_cs_o(bus_cs), .bus_we_o(bus_we), .bus_re_o(bus_re), .bus_rs_o(bus_rs),
    .bus_d_o(bus_d_out), .bus_d_oe_o(bus_d_oe), .bus_d_i(bus_d_in), .cfg_err_o(cfg_err)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  function automatic int fld(input logic [31:0] w, input int lo, input int n);
    return int'((w >> lo) & ((32'd1 << n) - 1));
  endfunction

  function automatic logic [31:0] mk_onoff(int cson, int csoff, int weon, int weoff, int reon, int reoff);
    return 32'(cson) | (32'(csoff) << 4) | (32'(weon) << 10) | (32'(weoff) << 14) |
           (32'(reon) << 20) | (32'(reoff) << 24);
  endfunction

  function automatic logic [31:0] mk_cyc(int wc, int rc, int acc);
    return 32'(wc) | (32'(rc) << 6) | (32'(acc) << 22);
  endfunction

  function automatic bit bad_cfg();
    int cson, csoff, weon, weoff, reon, reoff, wc, rc, acc;
    cson = fld(onoff, 0, 4);  csoff = fld(onoff, 4, 6);
    weon = fld(onoff, 10, 4); weoff = fld(onoff, 14, 6);
    reon = fld(onoff, 20, 4); reoff = fld(onoff, 24, 6);
    wc = fld(cyc, 0, 6); rc = fld(cyc, 6, 6); acc = fld(cyc, 22, 6);
    return !(weoff > weon && reoff > reon && csoff > cson && csoff >= weoff &&
             csoff >= reoff && wc >= weoff && rc >= reoff && acc > reon);
  endfunction

  // behavioural reference
  int m_busy, m_t, m_ph, m_rd, m_rs, m_rdv;
  logic [DW-1:0] m_wd, m_rdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_t = 0; m_ph = 0; m_rd = 0; m_rs = 0; m_rdv = 0;
      m_wd = '0; m_rdata = '0;
    end else begin
      int len, acc;
      bit step;
      m_rdv = 0;
      if (m_busy == 0) begin
        if (req_valid && !bad_cfg()) begin
          m_busy = 1; m_t = 0; m_ph = 0;
          m_rd = int'(req_read); m_rs = int'(req_data); m_wd = req_wdata;
        end
      end else begin
        len = m_rd != 0 ? fld(cyc, 6, 6) : fld(cyc, 0, 6);
        if (fld(onoff, 4, 6) > len) len = fld(onoff, 4, 6);
        acc = fld(cyc, 22, 6);
        step = !coarse || (m_ph != 0);
        if (coarse) m_ph = 1 - m_ph;
        if (step) begin
          if (m_rd != 0 && ((m_t + 1 == acc) || (m_t == len - 1 && acc > len))) m_rdata = bus_d_in;
          if (m_t == len - 1) begin m_busy = 0; m_rdv = m_rd; end
          else m_t++;
        end
      end
    end
  end

  function automatic bit win(int on, int off);
    return (m_busy != 0) && !bad_cfg() && m_t >= on && m_t < off;
  endfunction

  task automatic chk(input string tag, input string name, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", tag, name, got, exp, $time);
    end
  endtask

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      bit e_cs, e_we, e_re, e_oe;
      e_cs = win(fld(onoff, 0, 4), fld(onoff, 4, 6)) ^ pol[3];
      e_we = (win(fld(onoff, 10, 4), fld(onoff, 14, 6)) && m_rd == 0) ^ pol[2];
      e_re = (win(fld(onoff, 20, 4), fld(onoff, 24, 6)) && m_rd != 0) ^ pol[1];
      e_oe = (m_busy != 0) && (m_rd == 0);
      if (!rst_n) begin
        chk("R1", "cs", 32'(bus_cs), 32'(pol[3]));
        chk("R1", "we", 32'(bus_we), 32'(pol[2]));
        chk("R1", "re", 32'(bus_re), 32'(pol[1]));
        chk("R1", "rd_valid", 32'(rd_valid), 32'(0));
        chk("R1", "rd_data", 32'(rd_data), 32'(0));
        chk("R1", "ready", 32'(req_ready), 32'(!bad_cfg()));
      end else begin
        chk("R3", "cs", 32'(bus_cs), 32'(e_cs));
        chk("R4", "we", 32'(bus_we), 32'(e_we));
        chk("R4", "oe", 32'(bus_d_oe), 32'(e_oe));
        if (e_oe) chk("R4", "d_out", 32'(bus_d_out), 32'(m_wd));
        chk("R5", "re", 32'(bus_re), 32'(e_re));
        chk("R6", "rd_valid", 32'(rd_valid), 32'(m_rdv));
        chk("R6", "rd_data", 32'(rd_data), 32'(m_rdata));
        chk("R7", "ready", 32'(req_ready), 32'((m_busy == 0) && !bad_cfg()));
        chk("R8", "cfg_err", 32'(cfg_err), 32'(bad_cfg()));
        chk("R9", "rs", 32'(bus_rs), 32'(m_rs[0] ^ pol[0]));
      end
    end
  end

  // bus data changes every clock so the capture tick is visible
  always @(posedge clk) begin
    #2 bus_d_in = bus_d_in * 16'd5 + 16'h3a1;
  end

  task automatic access(input bit rd, input bit dat, input logic [DW-1:0] wd);
    @(posedge clk); #2;
    req_valid = 1'b1; req_read = rd; req_data = dat; req_wdata = wd;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #2;
    req_valid = 1'b0;
    do @(negedge clk); while (!req_ready);
  endtask

  task automatic set_cfg(input logic [31:0] o, input logic [31:0] c, input bit crs, input logic [3:0] p);
    @(posedge clk); #2;
    onoff = o; cyc = c; coarse = crs; pol = p;
  endtask

  task automatic mix(input logic [DW-1:0] seed);
    access(1'b0, 1'b0, seed);
    access(1'b0, 1'b1, seed ^ 16'h5a5a);
    access(1'b1, 1'b1, '0);
    access(1'b1, 1'b0, '0);
  endtask

  initial begin
    onoff = mk_onoff(1, 8, 2, 6, 2, 7);
    cyc   = mk_cyc(9, 10, 5);
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;                                   // R1 checked while in reset
    repeat (2) @(posedge clk);
    mix(16'h1234);                                     // R3 R4 R5 R6 R9 fine ticks
    set_cfg(onoff, cyc, 1'b1, 4'b0000); mix(16'h0f0f); // R2 coarse ticks
    set_cfg(onoff, cyc, 1'b0, 4'b1111); mix(16'hbeef); // R10 all inverted
    set_cfg(onoff, cyc, 1'b1, 4'b0101); mix(16'h7777); // R10 mixed polarity
    set_cfg(mk_onoff(1, 8, 2, 6, 2, 7), mk_cyc(9, 10, 12), 1'b0, 4'b0000);
    mix(16'h2468);                                     // R6 sample past cycle end
    set_cfg(mk_onoff(0, 12, 1, 6, 3, 5), mk_cyc(6, 5, 4), 1'b0, 4'b1000);
    mix(16'h1357);                                     // R7 cs_off stretches cycle
    set_cfg(mk_onoff(0, 1, 0, 1, 0, 1), mk_cyc(1, 1, 1), 1'b0, 4'b0000);
    mix(16'hffff);                                     // R7 single-tick cycles
    set_cfg(mk_onoff(0, 1, 0, 1, 0, 1), mk_cyc(1, 1, 1), 1'b1, 4'b0000);
    mix(16'h0001);                                     // R2 single tick coarse
    // R7 back-to-back: request held high
    set_cfg(mk_onoff(1, 4, 1, 3, 1, 4), mk_cyc(4, 5, 3), 1'b0, 4'b0000);
    @(posedge clk); #2; req_valid = 1'b1; req_read = 1'b0; req_data = 1'b1; req_wdata = 16'haaaa;
    repeat (20) @(posedge clk);
    #2 req_read = 1'b1;
    repeat (20) @(posedge clk);
    #2 req_valid = 1'b0;
    repeat (12) @(posedge clk);
    // R8 broken rules: requests must be refused, strobes quiet
    set_cfg(mk_onoff(1, 8, 3, 3, 2, 7), mk_cyc(9, 10, 5), 1'b0, 4'b1110);
    #1 req_valid = 1'b1;
    repeat (10) @(posedge clk);
    set_cfg(mk_onoff(1, 8, 2, 6, 4, 7), mk_cyc(9, 10, 3), 1'b0, 4'b0000);
    repeat (10) @(posedge clk);
    set_cfg(mk_onoff(1, 5, 2, 6, 2, 4), mk_cyc(9, 10, 3), 1'b0, 4'b0000);
    repeat (10) @(posedge clk);
    set_cfg(mk_onoff(1, 8, 2, 6, 2, 7), mk_cyc(5, 10, 3), 1'b0, 4'b0000);
    repeat (10) @(posedge clk);
    #2 req_valid = 1'b0;
    set_cfg(mk_onoff(1, 8, 2, 6, 2, 7), mk_cyc(9, 10, 5), 1'b0, 4'b0000);
    mix(16'hc0de);                                     // R8 recovery
    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule